// File: doc/BRIEF.md
# Emulator-Trap Entry Sequencer

This block carries out the processor state changes that follow the retirement of a software emulator-trap instruction. On an accepted request it captures the current status word, the address of the instruction after the trap, the table base and the system stack pointer. It then presents a rewritten status word in which privileged mode and the system stack are forced and the interrupt mask is set to a fixed level.

In normal operation it pushes the original status word and then the return address onto the system stack. Each push goes through a simple word-write port. It then reads the new program counter from a fixed slot of the vector table through a word-read port. Last, it hands back the updated stack pointer and the new program counter and re-arms exception-event detection. When a debug session is flagged, the stack is left alone. The status word and the return address go into two dedicated save registers, the block enters a debug state, and it requests an instruction fetch from the debug instruction register.

Every memory access waits for a ready handshake. The block is busy from acceptance to completion and ignores requests while busy.

Top module: `trap_entry_seq`

## Requirements
- R1: Reset drives `busy`, `done`, every strobe, both memory requests and `dbg_state` low. Reset is taken asynchronously and released on the clock through a two-stage synchronizer.
- R2: A `trap_req` seen while idle is accepted, and `busy` is high from the next cycle. It falls in the cycle after the one-cycle `done` pulse. A `trap_req` while `busy` is high starts no second sequence and changes no output.
- R3: Exactly once per accepted request, `stat_we` pulses with `stat_out` equal to the captured status word, with these changes: bit 7 (user mode) cleared, bit 5 (stack select) cleared, and bits 20:16 (interrupt mask) equal to 4. All other bits are unchanged.
- R4: In normal operation, the first memory access is a write to the captured stack pointer minus 4, carrying the status word as captured before the rewrite.
- R5: The second access is a write to the stack pointer minus 8, carrying the return address.
- R6: The third access is a read from table base plus 0x3D8. The read data appears on `pc_out` with `pc_we`, together with `ssp_out` equal to the stack pointer minus 8 with `ssp_we`, in the `done` cycle.
- R7: A memory request keeps its address and data and stays asserted until `mem_rdy` is sampled high. Write and read are never requested together, and the sequence only advances on `mem_rdy`.
- R8: With `dbg_mode` high at acceptance, `save_we` pulses with `save_stat` equal to the original status word and `save_pc` equal to the return address. No memory access, `ssp_we` or `pc_we` occurs.
- R9: In the debug path, `dbg_fetch` pulses once with `done`, and `dbg_state` goes high and stays high until a later normal-path entry clears it.
- R10: In the normal path, `evt_en` pulses once, in the `done` cycle after the vector read. The debug path never raises it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trap_req | input | 1 | Trap instruction retired |
| stat_in | input | 32 | Current status word |
| ret_addr | input | 32 | Address of the instruction after the trap |
| tbase | input | 32 | Vector table base |
| ssp_in | input | 32 | Current system stack pointer |
| dbg_mode | input | 1 | Debug session active |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Final-cycle pulse |
| stat_out | output | 32 | Rewritten status word |
| stat_we | output | 1 | Status word load strobe |
| ssp_out | output | 32 | Updated stack pointer |
| ssp_we | output | 1 | Stack pointer load strobe |
| pc_out | output | 32 | New program counter |
| pc_we | output | 1 | Program counter load strobe |
| save_stat | output | 32 | Status save register |
| save_pc | output | 32 | Return address save register |
| save_we | output | 1 | Save registers written |
| dbg_state | output | 1 | Debug state entered |
| dbg_fetch | output | 1 | Fetch request from debug instruction register |
| evt_en | output | 1 | Re-arm exception-event detection |
| mem_wr | output | 1 | Word write request |
| mem_rd | output | 1 | Word read request |
| mem_addr | output | 32 | Access address |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data |
| mem_rdy | input | 1 | Access complete |

## Verification
A wrong state in the sequencer shows at the memory port within one access. A missing or extra push, a swapped push order, or an address off by one word is visible in the access log as soon as the handshake for that access completes. Stale context capture shows in the address or data of the first write, or, in the debug path, in the save registers in the cycle of `save_we`. A stuck state is exposed by `busy` not falling one cycle after `done`. A request leaking through while busy is exposed by a second `stat_we` or extra accesses within a few cycles of the end.

// File: rtl/trap_pkg.sv
package trap_pkg;
  localparam int unsigned WORD_W  = 32;
  localparam int unsigned UM_POS  = 7;
  localparam int unsigned SS_POS  = 5;
  localparam int unsigned MSK_LSB = 16;
  localparam int unsigned MSK_W   = 5;
  localparam int unsigned MSK_VAL = 4;
  localparam int unsigned VEC_OFS = 32'h3D8;
  localparam int unsigned STEP    = 4;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_EDIT  = 3'd1,
    ST_PSH_S = 3'd2,
    ST_PSH_R = 3'd3,
    ST_VEC   = 3'd4,
    ST_FIN_N = 3'd5,
    ST_DSAVE = 3'd6,
    ST_FIN_D = 3'd7
  } seq_st_t;

  typedef enum logic [1:0] {
    AS_PUSH1 = 2'd0,
    AS_PUSH2 = 2'd1,
    AS_VECT  = 2'd2
  } addr_sel_t;
endpackage

// File: rtl/trap_stat_edit.sv
module trap_stat_edit #(
  parameter int unsigned W       = trap_pkg::WORD_W,
  parameter int unsigned UM_BIT  = trap_pkg::UM_POS,
  parameter int unsigned SS_BIT  = trap_pkg::SS_POS,
  parameter int unsigned M_LSB   = trap_pkg::MSK_LSB,
  parameter int unsigned M_W     = trap_pkg::MSK_W,
  parameter logic [M_W-1:0] M_VAL = M_W'(trap_pkg::MSK_VAL)
) (
  input  logic [W-1:0] st_old,
  output logic [W-1:0] st_new
);
  localparam int unsigned M_MSB = M_LSB + M_W - 1;

  for (genvar i = 0; i < W; i++) begin : g_bit
    if (i == UM_BIT || i == SS_BIT) begin : g_clr
      assign st_new[i] = 1'b0;
    end else if (i >= M_LSB && i <= M_MSB) begin : g_msk
      assign st_new[i] = M_VAL[i-M_LSB];
    end else begin : g_keep
      assign st_new[i] = st_old[i];
    end
  end
endmodule

// File: rtl/trap_seq_ctrl.sv
module trap_seq_ctrl
  import trap_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      req,
  input  logic      dbg_cap,
  input  logic      rdy,
  output logic      cap_en,
  output logic      busy,
  output logic      edit_we,
  output logic      wr_req,
  output logic      rd_req,
  output addr_sel_t asel,
  output logic      vec_cap,
  output logic      sv_we,
  output logic      fin_n,
  output logic      fin_d
);
  seq_st_t st_q, st_d;

  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_IDLE:  if (req) st_d = ST_EDIT;
      ST_EDIT:  st_d = dbg_cap ? ST_DSAVE : ST_PSH_S;
      ST_PSH_S: if (rdy) st_d = ST_PSH_R;
      ST_PSH_R: if (rdy) st_d = ST_VEC;
      ST_VEC:   if (rdy) st_d = ST_FIN_N;
      ST_FIN_N: st_d = ST_IDLE;
      ST_DSAVE: st_d = ST_FIN_D;
      ST_FIN_D: st_d = ST_IDLE;
      default:  st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  always_comb begin
    cap_en  = (st_q == ST_IDLE) && req;
    busy    = (st_q != ST_IDLE);
    edit_we = (st_q == ST_EDIT);
    wr_req  = (st_q == ST_PSH_S) || (st_q == ST_PSH_R);
    rd_req  = (st_q == ST_VEC);
    vec_cap = (st_q == ST_VEC) && rdy;
    sv_we   = (st_q == ST_DSAVE);
    fin_n   = (st_q == ST_FIN_N);
    fin_d   = (st_q == ST_FIN_D);
    case (st_q)
      ST_PSH_R: asel = AS_PUSH2;
      ST_VEC:   asel = AS_VECT;
      default:  asel = AS_PUSH1;
    endcase
  end
endmodule

// File: rtl/trap_ctx_regs.sv
module trap_ctx_regs
  import trap_pkg::*;
#(
  parameter int unsigned W    = WORD_W,
  parameter int unsigned OFS  = VEC_OFS,
  parameter int unsigned STP  = STEP
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cap_en,
  input  logic [W-1:0] st_in,
  input  logic [W-1:0] ra_in,
  input  logic [W-1:0] tb_in,
  input  logic [W-1:0] sp_in,
  input  logic         dbg_in,
  input  addr_sel_t    asel,
  input  logic         vec_cap,
  input  logic [W-1:0] rdata,
  input  logic         sv_we,
  input  logic         fin_n,
  output logic         dbg_q,
  output logic [W-1:0] st_q,
  output logic [W-1:0] addr,
  output logic [W-1:0] wdata,
  output logic [W-1:0] sp_new,
  output logic [W-1:0] pc_q,
  output logic [W-1:0] sst_q,
  output logic [W-1:0] spc_q,
  output logic         dst_q
);
  localparam logic [W-1:0] STEP1 = W'(STP);
  localparam logic [W-1:0] STEP2 = W'(2 * STP);
  localparam logic [W-1:0] VOFS  = W'(OFS);

  logic [W-1:0] ra_q, tb_q, sp_q;
  logic [W-1:0] pc_d, sst_d, spc_d;
  logic         dst_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= '0;
      ra_q  <= '0;
      tb_q  <= '0;
      sp_q  <= '0;
      dbg_q <= 1'b0;
    end else if (cap_en) begin
      st_q  <= st_in;
      ra_q  <= ra_in;
      tb_q  <= tb_in;
      sp_q  <= sp_in;
      dbg_q <= dbg_in;
    end
  end

  always_comb begin
    case (asel)
      AS_PUSH2: begin addr = sp_q - STEP2; wdata = ra_q; end
      AS_VECT:  begin addr = tb_q + VOFS;  wdata = '0;   end
      default:  begin addr = sp_q - STEP1; wdata = st_q; end
    endcase
    sp_new = sp_q - STEP2;
  end

  always_comb begin
    pc_d  = vec_cap ? rdata : pc_q;
    sst_d = sv_we ? st_q : sst_q;
    spc_d = sv_we ? ra_q : spc_q;
    dst_d = sv_we ? 1'b1 : (fin_n ? 1'b0 : dst_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q  <= '0;
      sst_q <= '0;
      spc_q <= '0;
      dst_q <= 1'b0;
    end else begin
      pc_q  <= pc_d;
      sst_q <= sst_d;
      spc_q <= spc_d;
      dst_q <= dst_d;
    end
  end
endmodule

// File: rtl/trap_entry_seq.sv
module trap_entry_seq
  import trap_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        trap_req,
  input  logic [31:0] stat_in,
  input  logic [31:0] ret_addr,
  input  logic [31:0] tbase,
  input  logic [31:0] ssp_in,
  input  logic        dbg_mode,
  output logic        busy,
  output logic        done,
  output logic [31:0] stat_out,
  output logic        stat_we,
  output logic [31:0] ssp_out,
  output logic        ssp_we,
  output logic [31:0] pc_out,
  output logic        pc_we,
  output logic [31:0] save_stat,
  output logic [31:0] save_pc,
  output logic        save_we,
  output logic        dbg_state,
  output logic        dbg_fetch,
  output logic        evt_en,
  output logic        mem_wr,
  output logic        mem_rd,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  input  logic [31:0] mem_rdata,
  input  logic        mem_rdy
);
  logic [1:0]  rs_q;
  logic        rst_s;
  logic        cap_en, dbg_q, vec_cap, sv_we, fin_n, fin_d, edit_we;
  addr_sel_t   asel;
  logic [31:0] st_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_s = rs_q[1];

  trap_seq_ctrl u_ctrl (
    .clk     (clk),
    .rst_n   (rst_s),
    .req     (trap_req),
    .dbg_cap (dbg_q),
    .rdy     (mem_rdy),
    .cap_en  (cap_en),
    .busy    (busy),
    .edit_we (edit_we),
    .wr_req  (mem_wr),
    .rd_req  (mem_rd),
    .asel    (asel),
    .vec_cap (vec_cap),
    .sv_we   (sv_we),
    .fin_n   (fin_n),
    .fin_d   (fin_d)
  );

  trap_ctx_regs u_ctx (
    .clk     (clk),
    .rst_n   (rst_s),
    .cap_en  (cap_en),
    .st_in   (stat_in),
    .ra_in   (ret_addr),
    .tb_in   (tbase),
    .sp_in   (ssp_in),
    .dbg_in  (dbg_mode),
    .asel    (asel),
    .vec_cap (vec_cap),
    .rdata   (mem_rdata),
    .sv_we   (sv_we),
    .fin_n   (fin_n),
    .dbg_q   (dbg_q),
    .st_q    (st_q),
    .addr    (mem_addr),
    .wdata   (mem_wdata),
    .sp_new  (ssp_out),
    .pc_q    (pc_out),
    .sst_q   (save_stat),
    .spc_q   (save_pc),
    .dst_q   (dbg_state)
  );

  trap_stat_edit u_edit (
    .st_old (st_q),
    .st_new (stat_out)
  );

  assign stat_we   = edit_we;
  assign save_we   = sv_we;
  assign ssp_we    = fin_n;
  assign pc_we     = fin_n;
  assign evt_en    = fin_n;
  assign dbg_fetch = fin_d;
  assign done      = fin_n | fin_d;
endmodule

// File: rtl/trap_entry_seq_chk.sv
module trap_entry_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        busy,
  input logic        done,
  input logic        stat_we,
  input logic [31:0] stat_out,
  input logic        ssp_we,
  input logic        pc_we,
  input logic        save_we,
  input logic        dbg_fetch,
  input logic        evt_en,
  input logic        mem_wr,
  input logic        mem_rd,
  input logic [31:0] mem_addr,
  input logic [31:0] mem_wdata,
  input logic        mem_rdy
);
  AST_DONE_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> busy); // R2
  AST_IDLE_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy); // R2
  AST_STAT_FIELDS: assert property (@(posedge clk) disable iff (!rst_n)
    stat_we |-> (!stat_out[7] && !stat_out[5] && stat_out[20:16] == 5'd4)); // R3
  AST_NO_RW_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_wr && mem_rd)); // R7
  AST_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr && !mem_rdy) |=> (mem_wr && $stable(mem_addr) && $stable(mem_wdata))); // R7
  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd && !mem_rdy) |=> (mem_rd && $stable(mem_addr))); // R7
  AST_SP_WITH_PC: assert property (@(posedge clk) disable iff (!rst_n)
    ssp_we |-> (pc_we && done)); // R6
  AST_SAVE_NO_MEM: assert property (@(posedge clk) disable iff (!rst_n)
    save_we |-> (!mem_wr && !mem_rd)); // R8
  AST_FETCH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_fetch |-> (done && !evt_en)); // R9
  AST_EVT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    evt_en |-> (done && !dbg_fetch)); // R10
endmodule

bind trap_entry_seq trap_entry_seq_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_s),
  .busy      (busy),
  .done      (done),
  .stat_we   (stat_we),
  .stat_out  (stat_out),
  .ssp_we    (ssp_we),
  .pc_we     (pc_we),
  .save_we   (save_we),
  .dbg_fetch (dbg_fetch),
  .evt_en    (evt_en),
  .mem_wr    (mem_wr),
  .mem_rd    (mem_rd),
  .mem_addr  (mem_addr),
  .mem_wdata (mem_wdata),
  .mem_rdy   (mem_rdy)
);

// File: tb/sim_trap_entry_seq.sv
`timescale 1ns/1ps
module sim_trap_entry_seq;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic trap_req = 1'b0;
  logic [31:0] stat_in = '0, ret_addr = '0, tbase = '0, ssp_in = '0;
  logic dbg_mode = 1'b0;
  logic busy, done, stat_we, ssp_we, pc_we, save_we, dbg_state, dbg_fetch, evt_en;
  logic mem_wr, mem_rd;
  logic [31:0] stat_out, ssp_out, pc_out, save_stat, save_pc, mem_addr, mem_wdata;
  logic [31:0] mem_rdata = '0;
  logic mem_rdy = 1'b0;

  always #2.5 clk = ~clk;

  trap_entry_seq u0 (.*);

  int checks = 0, errors = 0;
  int lat = 0, wcnt = 0;
  logic [31:0] vec_word = 32'h0;
  int acc_n = 0, n_stw = 0, n_done = 0, n_spw = 0, n_pcw = 0, n_sv = 0, n_df = 0, n_ev = 0;
  logic [31:0] acc_a [0:7];
  logic [31:0] acc_d [0:7];
  logic        acc_w [0:7];
  logic [31:0] c_stat, c_ssp, c_pc, c_sst, c_spc;

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  // memory model and monitor, away from the active edge
  always @(negedge clk) begin
    if (mem_rdy) mem_rdy = 1'b0;
    else if (mem_wr || mem_rd) begin
      if (wcnt >= lat) begin
        mem_rdy = 1'b1;
        mem_rdata = (mem_rd && mem_addr == tbase + 32'h3D8) ? vec_word : 32'hBAD0BAD0;
        if (acc_n < 8) begin
          acc_a[acc_n] = mem_addr;
          acc_d[acc_n] = mem_wdata;
          acc_w[acc_n] = mem_wr;
        end
        acc_n++;
        wcnt = 0;
      end else wcnt++;
    end
    if (stat_we) begin n_stw++; c_stat = stat_out; end
    if (ssp_we)  begin n_spw++; c_ssp = ssp_out; end
    if (pc_we)   begin n_pcw++; c_pc = pc_out; end
    if (save_we) n_sv++;
    if (dbg_fetch) n_df++;
    if (evt_en) n_ev++;
    if (done) n_done++;
  end

  task automatic clr_log();
    acc_n = 0; n_stw = 0; n_done = 0; n_spw = 0; n_pcw = 0; n_sv = 0; n_df = 0; n_ev = 0;
  endtask

  task automatic fire(input logic [31:0] st, input logic [31:0] ra, input logic [31:0] tb,
                      input logic [31:0] sp, input logic dbg);
    @(negedge clk);
    stat_in = st; ret_addr = ra; tbase = tb; ssp_in = sp; dbg_mode = dbg; trap_req = 1'b1;
    @(negedge clk);
    trap_req = 1'b0;
    stat_in = 32'hFFFF_FFFF; ret_addr = '0; ssp_in = '0; dbg_mode = ~dbg;
    chk("R2 busy after accept", {31'b0, busy}, 32'd1);
  endtask

  task automatic wait_done();
    int t = 0;
    while (n_done == 0 && t < 400) begin @(negedge clk); t++; end
    chk("R2 done seen", {31'b0, n_done != 0}, 32'd1);
    @(negedge clk);
    chk("R2 busy falls after done", {31'b0, busy}, 32'd0);
  endtask

  function automatic logic [31:0] edit(input logic [31:0] s);
    logic [31:0] r = s;
    r[7] = 1'b0; r[5] = 1'b0; r[20:16] = 5'd4;
    return r;
  endfunction

  task automatic t_reset();
    chk("R1 busy in reset", {31'b0, busy}, 32'd0);
    chk("R1 strobes in reset", {22'b0, done, stat_we, ssp_we, pc_we, save_we, dbg_fetch,
                                evt_en, mem_wr, mem_rd, dbg_state}, 32'd0);
  endtask

  task automatic t_normal(input logic [31:0] st, input logic [31:0] sp, input logic [31:0] tb,
                          input logic [31:0] ra, input int l, input logic [31:0] vw);
    clr_log(); lat = l; vec_word = vw;
    fire(st, ra, tb, sp, 1'b0);
    wait_done();
    chk("R3 one status load", n_stw, 32'd1);
    chk("R3 status rewrite", c_stat, edit(st));
    chk("R7 three accesses", acc_n, 32'd3);
    chk("R4 first write addr", acc_a[0], sp - 32'd4);
    chk("R4 first write data", acc_d[0], st);
    chk("R4 first is write", {31'b0, acc_w[0]}, 32'd1);
    chk("R5 second write addr", acc_a[1], sp - 32'd8);
    chk("R5 second write data", acc_d[1], ra);
    chk("R6 vector read addr", acc_a[2], tb + 32'h3D8);
    chk("R6 third is read", {31'b0, acc_w[2]}, 32'd0);
    chk("R6 new pc", c_pc, vw);
    chk("R6 new sp", c_ssp, sp - 32'd8);
    chk("R6 strobes once", n_spw + n_pcw, 32'd2);
    chk("R10 evt once", n_ev, 32'd1);
    chk("R8 no save in normal", n_sv, 32'd0);
    chk("R9 no debug fetch in normal", n_df, 32'd0);
    chk("R9 debug state clear after normal", {31'b0, dbg_state}, 32'd0);
  endtask

  task automatic t_debug(input logic [31:0] st, input logic [31:0] ra);
    clr_log(); lat = 0;
    fire(st, ra, 32'h1000_0000, 32'h0000_8000, 1'b1);
    wait_done();
    chk("R3 status rewrite debug", c_stat, edit(st));
    chk("R8 save status", save_stat, st);
    chk("R8 save pc", save_pc, ra);
    chk("R8 one save", n_sv, 32'd1);
    chk("R8 no memory", acc_n, 32'd0);
    chk("R8 no sp/pc load", n_spw + n_pcw, 32'd0);
    chk("R9 one debug fetch", n_df, 32'd1);
    chk("R9 debug state set", {31'b0, dbg_state}, 32'd1);
    chk("R10 no evt in debug", n_ev, 32'd0);
  endtask

  task automatic t_ignore();
    clr_log(); lat = 3; vec_word = 32'h0000_4444;
    fire(32'h0000_00A0, 32'h0000_2004, 32'h0002_0000, 32'h0000_1000, 1'b0);
    repeat (4) @(negedge clk);
    stat_in = 32'h1234_5678; ssp_in = 32'h0000_9000; dbg_mode = 1'b1; trap_req = 1'b1;
    @(negedge clk); trap_req = 1'b0;
    chk("R7 held while waiting", {31'b0, busy}, 32'd1);
    wait_done();
    repeat (6) @(negedge clk);
    chk("R2 ignored req: one status load", n_stw, 32'd1);
    chk("R2 ignored req: one done", n_done, 32'd1);
    chk("R2 ignored req: three accesses", acc_n, 32'd3);
    chk("R2 ignored req: sp from first", c_ssp, 32'h0000_0FF8);
    chk("R2 idle after", {31'b0, busy}, 32'd0);
  endtask

  initial begin
    int wd = 0;
    fork
      begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        t_reset();
        t_normal(32'h00FF_00A5, 32'h0000_1000, 32'h0001_0000, 32'h0000_0204, 0, 32'hCAFE_0000);
        t_normal(32'hFFFF_FFFF, 32'h0000_0008, 32'hFFFF_FC28, 32'h8000_0002, 2, 32'h1357_9BDF);
        t_debug(32'h0013_00A0, 32'h0000_3334);
        t_normal(32'h0000_0000, 32'h2000_0000, 32'h0000_0000, 32'h0000_0000, 1, 32'h0000_0010);
        t_ignore();
      end
      begin
        while (wd < 20000) begin @(negedge clk); wd++; end
        checks++; errors++;
        $display("FAIL watchdog actual=%0d expected=<20000", wd);
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule